// File: doc/BRIEF.md
# Burst column address generator

This block produces the column addresses for a single memory burst. A start pulse loads an 8-bit starting column together with a burst-length code and a wrap selector. The block then presents one column per beat on a valid/ready output stream. The beat counter moves only when a beat is accepted. The final beat of every fixed-length burst carries a last flag.

Two orderings are provided. Sequential wrap counts the low bits upward inside the aligned block. Interleave wrap XORs the beat index into the low bits. A page-length burst, legal only with sequential wrap, walks through all 256 columns modulo the page and runs until a stop pulse or a new start ends it. A start pulse is taken on any cycle, so it can cut into a burst that is already running.

Back-pressure: a beat counts as transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the column and flags stay frozen. `start` and `stop` act on the edge where they are sampled, whatever the state of `out_ready`.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_last` and `cfg_err` are low.
- R2: A legal start raises `out_valid` on the next cycle with `out_col` equal to the sampled `start_col` (beat 0).
- R3: Length code 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Code 7 selects a full page. Codes 4, 5 and 6 are reserved and rejected.
- R4: With `wrap_il` low and length L, beat i has low log2(L) bits equal to (start low bits + i) mod L. The upper bits equal those of the start column.
- R5: With `wrap_il` high and length L, beat i has low log2(L) bits equal to the start low bits XOR i. The upper bits equal those of the start column.
- R6: A full-page burst gives (start + i) mod 256 on beat i and never asserts `out_last`. It continues until a stop or a new start.
- R7: `out_last` is high exactly on beat L-1 of a fixed-length burst. After that beat is accepted, `out_valid` is low on the next cycle unless a start was sampled.
- R8: While `out_valid` is high and `out_ready` is low, with no start or stop, `out_valid`, `out_col` and `out_last` keep their values into the next cycle.
- R9: A start sampled during a burst ends that burst at once. The beat presented on that edge counts if `out_ready` is high. The next cycle shows beat 0 of the new burst. Start takes priority over stop.
- R10: A stop without a start makes `out_valid` low on the next cycle.
- R11: A start asking for a full page with interleave wrap, or a reserved length code, starts no burst. It ends any burst in progress, and `cfg_err` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load a new burst from the fields below |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst-length code (see R3) |
| wrap_il | input | 1 | 0 = sequential wrap, 1 = interleave wrap |
| stop | input | 1 | Terminate the running burst |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A column beat is presented |
| out_col | output | 8 | Column address of the current beat |
| out_last | output | 1 | Current beat is the final one of a fixed-length burst |
| cfg_err | output | 1 | One-cycle flag after a rejected start |

## Verification
Some rules can be judged from the ports alone, and the assertions check these on every cycle:
- `out_last` only with `out_valid`, and the stream drops after the last beat is accepted.
- Column and flags hold still under back-pressure.
- A stop empties the stream.
- Every start yields either beat 0 at the sampled column or a single error cycle, never both.

The actual column sequences need the programmed length and wrap mode, so only the bench scenarios can show them. These cover:
- sequential and interleave orderings from unaligned starts,
- full-page wrap past column 255,
- a burst cut by a new start,
- random stalls,
- both kinds of rejected start.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  // Number of low column bits that take part in wrapping for a fixed length.
  function automatic int unsigned len_log2(input logic [2:0] code);
    case (code)
      LEN_2:   len_log2 = 1;
      LEN_4:   len_log2 = 2;
      LEN_8:   len_log2 = 3;
      default: len_log2 = 0;
    endcase
  endfunction

  function automatic logic code_is_fixed(input logic [2:0] code);
    code_is_fixed = (code == LEN_1) || (code == LEN_2) ||
                    (code == LEN_4) || (code == LEN_8);
  endfunction

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code,
  input  logic             wrap_il,
  output logic             legal,
  output logic             full,
  output logic [COL_W-1:0] wrap_mask
);

  logic        fixed_len;
  int unsigned lg;

  always_comb begin
    fixed_len = code_is_fixed(len_code);
    full      = (len_code == LEN_PAGE);
    legal     = fixed_len || (full && !wrap_il);
    lg        = len_log2(len_code);
  end

  // A page burst wraps over every column bit; a fixed burst over log2(L) bits.
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = full || (b < lg);
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             legal,
  input  logic             full,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             wrap_il,
  input  logic             stop,
  input  logic             ready,
  output logic             active,
  output logic             last,
  output logic             err,
  output logic [COL_W-1:0] beat_cnt,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] mask_q,
  output logic             il_q
);

  logic full_q;
  logic take;

  assign take = active && ready;
  assign last = active && !full_q && (beat_cnt == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      err      <= 1'b0;
      beat_cnt <= '0;
      base_col <= '0;
      mask_q   <= '0;
      il_q     <= 1'b0;
      full_q   <= 1'b0;
    end else if (start) begin
      beat_cnt <= '0;
      if (legal) begin
        active   <= 1'b1;
        err      <= 1'b0;
        base_col <= start_col;
        mask_q   <= wrap_mask;
        il_q     <= wrap_il;
        full_q   <= full;
      end else begin
        active <= 1'b0;
        err    <= 1'b1;
      end
    end else begin
      err <= 1'b0;
      if (stop) begin
        active <= 1'b0;
      end else if (take) begin
        if (last) begin
          active <= 1'b0;
        end else begin
          beat_cnt <= beat_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             wrap_il,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_sum;

  assign seq_sum = base_col + beat_cnt;

  // Per bit: outside the wrap field keep the start bit, inside it pick the
  // sequential sum or the interleave XOR.
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = !wrap_mask[b] ? base_col[b] :
                    (wrap_il ? (base_col[b] ^ beat_cnt[b]) : seq_sum[b]);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             wrap_il,
  input  logic             stop,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col,
  output logic             out_last,
  output logic             cfg_err
);

  logic             legal;
  logic             full;
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] beat_cnt;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] mask_q;
  logic             il_q;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code  (len_code),
    .wrap_il   (wrap_il),
    .legal     (legal),
    .full      (full),
    .wrap_mask (wrap_mask)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .legal     (legal),
    .full      (full),
    .wrap_mask (wrap_mask),
    .wrap_il   (wrap_il),
    .stop      (stop),
    .ready     (out_ready),
    .active    (out_valid),
    .last      (out_last),
    .err       (cfg_err),
    .beat_cnt  (beat_cnt),
    .base_col  (base_col),
    .mask_q    (mask_q),
    .il_q      (il_q)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_col  (base_col),
    .beat_cnt  (beat_cnt),
    .wrap_mask (mask_q),
    .wrap_il   (il_q),
    .col       (out_col)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic             out_ready,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col,
  input logic             out_last,
  input logic             cfg_err
);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !start) |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start && !stop)
      |=> (out_valid && $stable(out_col) && $stable(out_last)));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !out_valid);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cfg_err || (out_valid && out_col == $past(start_col))));

  p_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !cfg_err);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .stop      (stop),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_col   (out_col),
  .out_last  (out_last),
  .cfg_err   (cfg_err)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_P = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       wrap_il = 1'b0;
  logic       stop = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_col;
  logic       out_last;
  logic       cfg_err;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .wrap_il(wrap_il), .stop(stop),
    .out_ready(out_ready), .out_valid(out_valid), .out_col(out_col),
    .out_last(out_last), .cfg_err(cfg_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R4";
  logic [8:0] exp_q[$];

  bit         stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (stall_en) begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= lfsr[0] | lfsr[5];
    end else begin
      out_ready <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] base, input logic [2:0] code,
                                         input bit il, input int i);
    logic [7:0] m;
    logic [7:0] low;
    if (code == 3'd7) return 8'((int'(base) + i) % 256);
    m   = 8'((1 << code) - 1);
    low = il ? (base ^ 8'(i)) : 8'(int'(base) + i);
    return (base & ~m) | (low & m);
  endfunction

  // Monitor: scoreboard pop on each accepted beat, plus the hold rule.
  logic [7:0] prev_col = '0;
  logic       prev_last = 1'b0;
  bit         prev_hold = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (prev_hold)
          chk(out_valid && out_col == prev_col && out_last == prev_last,
              $sformatf("R8 hold: valid=%0b col=%0d last=%0b expected valid=1 col=%0d last=%0b",
                        out_valid, out_col, out_last, prev_col, prev_last));
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, $sformatf("%s unexpected beat col=%0d expected none", cur_tag, out_col));
          end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(out_col == e[7:0] && out_last == e[8],
                $sformatf("%s beat: col=%0d last=%0b expected col=%0d last=%0b",
                          cur_tag, out_col, out_last, e[7:0], e[8]));
          end
        end
        prev_hold = out_valid && !out_ready && !start && !stop;
        prev_col  = out_col;
        prev_last = out_last;
      end
    end
  end

  task automatic push_beats(input logic [7:0] col, input logic [2:0] code, input bit il,
                            input int from, input int upto, input int len);
    for (int i = from; i < upto; i++)
      exp_q.push_back({(code != 3'd7) && (i == len - 1), exp_col(col, code, il, i)});
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() != 0) @(negedge clk);
    #5;
    chk(!out_valid, $sformatf("%s end: valid=%0b expected 0", tag, out_valid));
  endtask

  task automatic burst(input logic [7:0] col, input logic [2:0] code, input bit il,
                       input string tag);
    int len;
    len = 1 << code;
    @(negedge clk);
    cur_tag   = tag;
    start     = 1'b1;
    start_col = col;
    len_code  = code;
    wrap_il   = il;
    push_beats(col, code, il, 0, len, len);
    @(negedge clk);
    start = 1'b0;
    drain("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(!out_valid && !out_last && !cfg_err,
        $sformatf("R1 reset: valid=%0b last=%0b err=%0b expected 0 0 0", out_valid, out_last, cfg_err));
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(!out_valid && !cfg_err,
        $sformatf("R1 after reset: valid=%0b err=%0b expected 0 0", out_valid, cfg_err));

    // R2: first beat equals the start column.
    @(negedge clk);
    start = 1'b1; start_col = 8'h37; len_code = 3'd2; wrap_il = 1'b0; cur_tag = "R2";
    push_beats(8'h37, 3'd2, 1'b0, 0, 4, 4);
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(out_valid && out_col == 8'h37,
        $sformatf("R2 first beat: valid=%0b col=%0d expected 1 %0d", out_valid, out_col, 8'h37));
    drain("R7");

    // R3/R4/R7: each fixed length, sequential, unaligned starts.
    burst(8'h55, 3'd0, 1'b0, "R3");
    burst(8'h13, 3'd1, 1'b0, "R4");
    burst(8'h2E, 3'd2, 1'b0, "R4");
    burst(8'hFD, 3'd3, 1'b0, "R4");
    // R5: interleave.
    burst(8'h13, 3'd1, 1'b1, "R5");
    burst(8'h2E, 3'd2, 1'b1, "R5");
    burst(8'h2D, 3'd3, 1'b1, "R5");
    burst(8'h80, 3'd3, 1'b1, "R5");

    // R8: random back-pressure over both orderings.
    stall_en = 1'b1;
    burst(8'hC6, 3'd3, 1'b0, "R8");
    burst(8'hC6, 3'd3, 1'b1, "R8");
    burst(8'h09, 3'd2, 1'b1, "R8");
    stall_en = 1'b0;
    @(negedge clk);

    // R9: a new start cuts in after four beats of an 8-beat burst.
    @(negedge clk);
    cur_tag = "R9";
    start = 1'b1; start_col = 8'h40; len_code = 3'd3; wrap_il = 1'b0;
    push_beats(8'h40, 3'd3, 1'b0, 0, 4, 8);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; start_col = 8'h9A; len_code = 3'd2; wrap_il = 1'b1; stop = 1'b1;
    push_beats(8'h9A, 3'd2, 1'b1, 0, 4, 4);
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    drain("R9");

    // R6/R10: full page wraps past 255, then stop.
    @(negedge clk);
    cur_tag = "R6";
    start = 1'b1; start_col = 8'hFD; len_code = 3'd7; wrap_il = 1'b0;
    push_beats(8'hFD, 3'd7, 1'b0, 0, 5, 0);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    #5;
    chk(!out_valid && exp_q.size() == 0,
        $sformatf("R10 stop: valid=%0b pending=%0d expected 0 0", out_valid, exp_q.size()));

    // R11: full page with interleave is rejected.
    @(negedge clk);
    start = 1'b1; start_col = 8'h10; len_code = 3'd7; wrap_il = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(cfg_err && !out_valid,
        $sformatf("R11 page+interleave: err=%0b valid=%0b expected 1 0", cfg_err, out_valid));
    @(negedge clk);
    #5;
    chk(!cfg_err, $sformatf("R11 err pulse: err=%0b expected 0", cfg_err));

    // R3/R11: reserved code 5 is rejected.
    @(negedge clk);
    start = 1'b1; start_col = 8'h22; len_code = 3'd5; wrap_il = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(cfg_err && !out_valid,
        $sformatf("R3 reserved code: err=%0b valid=%0b expected 1 0", cfg_err, out_valid));

    // R11: a rejected start aborts a running page burst.
    @(negedge clk);
    cur_tag = "R11";
    start = 1'b1; start_col = 8'h00; len_code = 3'd7; wrap_il = 1'b0;
    push_beats(8'h00, 3'd7, 1'b0, 0, 2, 0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; len_code = 3'd6;
    @(negedge clk);
    start = 1'b0;
    #5;
    chk(cfg_err && !out_valid,
        $sformatf("R11 abort: err=%0b valid=%0b expected 1 0", cfg_err, out_valid));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule